// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block holds the integer registers of a 64-bit core: thirty-two architectural indices, two combinational read ports and one write port that commits on the rising clock edge. A single privilege flag changes where some indices land. While the flag is high, a fixed, non-contiguous group of eight indices is served by a separate eight-entry shadow bank rather than the main array. Privileged code therefore gets private scratch registers with no save or restore and no copying. The ordinary copies stay untouched and reappear as soon as the flag drops.

The steering is a pure address decode. The flag value present in a cycle applies to both reads in that cycle and to the write that commits at the end of it. Index 31 is a hard zero. Reset clears every storage entry in both banks.

Top module: `mode_banked_rf`

## Requirements
- R1: With the privilege flag low, every index 0..30 reads and writes the main array; a value written to index i is returned by a later read of index i.
- R2: With the privilege flag high, indices 8, 9, 10, 11, 12, 13 and 14 reach shadow entries 0, 1, 2, 3, 4, 5 and 6 respectively.
- R3: With the privilege flag high, index 25 reaches shadow entry 7.
- R4: With the privilege flag high, every index other than 8..14, 25 and 31 reaches the same main-array entry it reaches with the flag low.
- R5: Index 31 reads as zero on both read ports in both modes, and a write to index 31 changes no register.
- R6: Every main and shadow entry stores and returns all 64 data bits unchanged, including all-ones and patterns with only the top and bottom bits set.
- R7: Reads are combinational and both ports decode independently using the current flag: a write is not visible during its own cycle and is visible from the cycle after its clock edge.
- R8: An active-low reset clears every main and shadow entry to zero.
- R9: Changing the flag moves no data: a main-array value at index 8..14 or 25 survives privileged writes to the same index and reads back once the flag is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| priv_i | input | 1 | Privilege flag; high steers the shadowed indices to the shadow bank |
| ra_idx_i | input | 5 | Read port A index |
| ra_data_o | output | 64 | Read port A data, combinational |
| rb_idx_i | input | 5 | Read port B index |
| rb_data_o | output | 64 | Read port B data, combinational |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write index |
| wr_data_i | input | 64 | Write data |

## Verification
A wrong decode shows at the read ports in the same cycle the index is presented, because reads are combinational; a misrouted write shows one cycle later, when a read of the intended index in the intended mode returns a stale value while a read of some other index, or of the same index in the other mode, returns the new one. The bench fills both banks with values unique to each entry, so any crossed mapping, lost bit or data moved by a mode change surfaces as a mismatch on the first read that touches the affected entry. A write that leaks into index 31 appears on the very next read of 31 as a non-zero value.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

    // Architectural index space
    localparam int RF_REGS      = 32;
    localparam int RF_AW        = $clog2(RF_REGS);
    localparam int RF_ZERO      = RF_REGS - 1;

    // Shadow bank geometry: a contiguous run plus one extra index
    localparam int RF_SHD       = 8;
    localparam int RF_SW        = $clog2(RF_SHD);
    localparam int RF_SHD_LO    = 8;
    localparam int RF_SHD_RUN   = RF_SHD - 1;
    localparam int RF_SHD_HI    = RF_SHD_LO + RF_SHD_RUN - 1;
    localparam int RF_SHD_EXTRA = 25;

    // Where one port's index lands
    typedef struct packed {
        logic             is_zero;
        logic             to_shadow;
        logic [RF_SW-1:0] shd_idx;
        logic [RF_AW-1:0] main_idx;
    } rf_route_t;

endpackage

// File: rtl/rf_route.sv
`timescale 1ns/1ps
module rf_route
    import rf_pkg::*;
(
    input  logic             priv_i,
    input  logic [RF_AW-1:0] idx_i,
    output rf_route_t        route_o
);

    logic [RF_AW-1:0] run_off;
    logic             in_run;
    logic             is_extra;

    always_comb begin
        run_off  = idx_i - RF_AW'(RF_SHD_LO);
        in_run   = (idx_i >= RF_AW'(RF_SHD_LO)) && (idx_i <= RF_AW'(RF_SHD_HI));
        is_extra = (idx_i == RF_AW'(RF_SHD_EXTRA));

        route_o          = '0;
        route_o.main_idx = idx_i;
        route_o.is_zero  = (idx_i == RF_AW'(RF_ZERO));
        if (priv_i && in_run) begin
            route_o.to_shadow = 1'b1;
            route_o.shd_idx   = run_off[RF_SW-1:0];
        end else if (priv_i && is_extra) begin
            route_o.to_shadow = 1'b1;
            route_o.shd_idx   = RF_SW'(RF_SHD - 1);
        end
    end

    always_comb begin
        // R1
        if (priv_i == 1'b0) begin
            user_no_shadow_chk: assert (!route_o.to_shadow);
        end
        // R3
        if (priv_i == 1'b1 && idx_i == RF_AW'(RF_SHD_EXTRA)) begin
            extra_map_chk: assert (route_o.to_shadow && route_o.shd_idx == RF_SW'(RF_SHD - 1));
        end
        // R5
        if (idx_i == RF_AW'(RF_ZERO)) begin
            zero_not_shadow_chk: assert (!route_o.to_shadow);
        end
    end

endmodule

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     wa_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [AW-1:0]     ra_i,
    input  logic [AW-1:0]     rb_i,
    output logic [DATA_W-1:0] ra_o,
    output logic [DATA_W-1:0] rb_o
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } bank_t;

    bank_t state_d;
    bank_t state_q;

    always_comb begin
        state_d = state_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (we_i && (wa_i == AW'(e))) begin
                state_d.mem[e] = wd_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ra_o = state_q.mem[ra_i];
    assign rb_o = state_q.mem[rb_i];

    // R6
    bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (state_q.mem[$past(wa_i)] == $past(wd_i)));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(state_q));

endmodule

// File: rtl/mode_banked_rf.sv
`timescale 1ns/1ps
module mode_banked_rf
    import rf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic [4:0]        ra_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [4:0]        rb_idx_i,
    output logic [DATA_W-1:0] rb_data_o,
    input  logic              we_i,
    input  logic [4:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int NPORT = 3;   // read A, read B, write
    localparam int P_RA  = 0;
    localparam int P_RB  = 1;
    localparam int P_WR  = 2;

    logic [NPORT-1:0][RF_AW-1:0] port_idx;
    rf_route_t                   rt [NPORT];

    assign port_idx[P_RA] = ra_idx_i;
    assign port_idx[P_RB] = rb_idx_i;
    assign port_idx[P_WR] = wr_idx_i;

    // One decoder per port, each using the current flag
    for (genvar p = 0; p < NPORT; p++) begin : g_route
        rf_route u_route (
            .priv_i  (priv_i),
            .idx_i   (port_idx[p]),
            .route_o (rt[p])
        );
    end

    logic              main_we;
    logic              shd_we;
    logic [DATA_W-1:0] main_a, main_b;
    logic [DATA_W-1:0] shd_a,  shd_b;

    always_comb begin
        main_we = we_i && !rt[P_WR].is_zero && !rt[P_WR].to_shadow;
        shd_we  = we_i && rt[P_WR].to_shadow;
    end

    rf_bank #(.DATA_W(DATA_W), .DEPTH(RF_REGS)) u_main (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (main_we),
        .wa_i (rt[P_WR].main_idx),
        .wd_i (wr_data_i),
        .ra_i (rt[P_RA].main_idx),
        .rb_i (rt[P_RB].main_idx),
        .ra_o (main_a),
        .rb_o (main_b)
    );

    rf_bank #(.DATA_W(DATA_W), .DEPTH(RF_SHD)) u_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (shd_we),
        .wa_i (rt[P_WR].shd_idx),
        .wd_i (wr_data_i),
        .ra_i (rt[P_RA].shd_idx),
        .rb_i (rt[P_RB].shd_idx),
        .ra_o (shd_a),
        .rb_o (shd_b)
    );

    always_comb begin
        if (rt[P_RA].is_zero)        ra_data_o = '0;
        else if (rt[P_RA].to_shadow) ra_data_o = shd_a;
        else                         ra_data_o = main_a;

        if (rt[P_RB].is_zero)        rb_data_o = '0;
        else if (rt[P_RB].to_shadow) rb_data_o = shd_b;
        else                         rb_data_o = main_b;
    end

    // R5
    zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx_i == 5'd31) |-> (ra_data_o == '0));

    // R5
    zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx_i == 5'd31) |-> (rb_data_o == '0));

    // R9
    user_write_no_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_i) |-> !shd_we);

    // R7
    wr_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wr_idx_i != 5'd31) |=>
            (!(ra_idx_i == $past(wr_idx_i) && priv_i == $past(priv_i))
             || ra_data_o == $past(wr_data_i)));

endmodule

// File: tb/tb_mode_banked_rf.sv
`timescale 1ns/1ps
module tb_mode_banked_rf;

    localparam int  DW       = 64;
    localparam time TCLK     = 20ns;
    localparam int  WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv = 1'b0;
    logic [4:0]    ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic [DW-1:0] ra_data, rb_data;
    logic          we = 1'b0;
    logic [DW-1:0] wr_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    mode_banked_rf dut (
        .clk(clk), .rst_n(rst_n), .priv_i(priv),
        .ra_idx_i(ra_idx), .ra_data_o(ra_data),
        .rb_idx_i(rb_idx), .rb_data_o(rb_data),
        .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
    );

    function automatic logic [63:0] mval(int i);
        return 64'hC0DE_0000_0000_0000 | (64'(i) << 32) | 64'(i * 3 + 1);
    endfunction

    function automatic logic [63:0] sval(int k);
        return 64'h5A00_0000_0000_0000 | (64'(k) << 40) | 64'(k + 100);
    endfunction

    typedef struct packed {
        logic        p;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [63:0] ea;
        logic [63:0] eb;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 5'd8,  5'd25, mval(8),  mval(25)},
        '{1'b1, 5'd8,  5'd25, sval(0),  sval(7)},
        '{1'b1, 5'd14, 5'd15, sval(6),  mval(15)},
        '{1'b1, 5'd7,  5'd24, mval(7),  mval(24)},
        '{1'b0, 5'd14, 5'd31, mval(14), 64'd0},
        '{1'b1, 5'd31, 5'd26, 64'd0,    mval(26)},
        '{1'b1, 5'd11, 5'd0,  sval(3),  mval(0)},
        '{1'b0, 5'd30, 5'd9,  mval(30), mval(9)}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic p, int idx, logic [63:0] d);
        @(negedge clk);
        priv = p; we = 1'b1; wr_idx = 5'(idx); wr_data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic p, int a, int b);
        priv = p; ra_idx = 5'(a); rb_idx = 5'(b);
        #2;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state, every index in both modes
        for (int i = 0; i < 32; i++) begin
            rd(1'b0, i, i);
            check("R8 user", ra_data, 64'd0);
            rd(1'b1, i, i);
            check("R8 priv", rb_data, 64'd0);
        end

        // Fill main array in user mode, including a discarded write to 31
        for (int i = 0; i < 32; i++) wr(1'b0, i, mval(i));
        // Fill shadow bank in privileged mode (R2, R3)
        for (int k = 0; k < 7; k++) wr(1'b1, 8 + k, sval(k));
        wr(1'b1, 25, sval(7));
        wr(1'b1, 31, 64'hDEAD_BEEF_DEAD_BEEF);

        // R1 / R5: user mode sees main values, 31 is zero
        for (int i = 0; i < 32; i++) begin
            rd(1'b0, i, 31 - i);
            check("R1 user port A", ra_data, (i == 31) ? 64'd0 : mval(i));
            check("R5 user port B", rb_data, (i == 0) ? 64'd0 : mval(31 - i));
        end

        // R2 / R3 / R4: privileged mode mapping
        for (int i = 0; i < 32; i++) begin
            rd(1'b1, i, i);
            if (i >= 8 && i <= 14) check("R2 priv run", ra_data, sval(i - 8));
            else if (i == 25)      check("R3 priv extra", ra_data, sval(7));
            else if (i == 31)      check("R5 priv zero", ra_data, 64'd0);
            else                   check("R4 priv main", ra_data, mval(i));
        end

        // R7: vector table, both ports at once
        foreach (VECS[v]) begin
            rd(VECS[v].p, int'(VECS[v].a), int'(VECS[v].b));
            check("R7 table port A", ra_data, VECS[v].ea);
            check("R7 table port B", rb_data, VECS[v].eb);
        end

        // R6: full-width patterns in main and shadow
        wr(1'b0, 30, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(1'b0, 30, 30);
        check("R6 main ones", ra_data, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(1'b1, 12, 64'h8000_0000_0000_0001);
        rd(1'b1, 12, 12);
        check("R6 shadow edges", rb_data, 64'h8000_0000_0000_0001);
        rd(1'b0, 12, 12);
        check("R9 main 12 kept", ra_data, mval(12));

        // R7: write not visible in its own cycle, visible after the edge
        @(negedge clk);
        priv = 1'b0; we = 1'b1; wr_idx = 5'd3; wr_data = 64'h0123_4567_89AB_CDEF;
        ra_idx = 5'd3; rb_idx = 5'd3;
        #2;
        check("R7 same cycle old", ra_data, mval(3));
        @(negedge clk);
        we = 1'b0;
        #2;
        check("R7 next cycle new", rb_data, 64'h0123_4567_89AB_CDEF);

        // R9: privileged write to 8 and 25 leaves main copies intact
        wr(1'b1, 8, 64'h1111_2222_3333_4444);
        wr(1'b1, 25, 64'h5555_6666_7777_8888);
        rd(1'b0, 8, 25);
        check("R9 main 8", ra_data, mval(8));
        check("R9 main 25", rb_data, mval(25));
        rd(1'b1, 8, 25);
        check("R9 shadow 8", ra_data, 64'h1111_2222_3333_4444);
        check("R9 shadow 25", rb_data, 64'h5555_6666_7777_8888);

        // R5: write to 31 in user mode touches nothing
        wr(1'b0, 31, 64'hFFFF_0000_FFFF_0000);
        rd(1'b0, 31, 30);
        check("R5 zero after write", ra_data, 64'd0);
        check("R5 neighbour intact", rb_data, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: reset again clears both banks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, 3, 30);
        check("R8 main cleared", ra_data, 64'd0);
        check("R8 main cleared B", rb_data, 64'd0);
        rd(1'b1, 8, 25);
        check("R8 shadow cleared", ra_data, 64'd0);
        check("R8 shadow cleared B", rb_data, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule